// File: doc/BRIEF.md
# Latching Push-Pull PWM Generator

This block drives the two switches of a push-pull converter from a single digital ramp. A counter runs over a fixed number of cycles, which sets the period. At the start of each period there is a blanking interval, the clock pulse, during which both drives are held low. This interval sets the dead time, and it is also the only event that re-arms the pulse latch. After blanking, the drive for the current phase goes high. It stays high until the counter reaches the captured duty value, a shutdown request arrives, or the period ends. Once the drive has been ended for any reason, it cannot come back within that period.

A phase toggle hands successive periods to drive A and drive B in turn, so each drive gets at most one pulse every two periods. An external sync pulse restarts the period at once, which lets several instances share one timebase. A one-cycle period strobe marks the first cycle of every period for neighbouring logic.

The pulse latch is a four-state machine:
- `ST_BLANK` is the clock pulse with the latch armed.
- `ST_BLANK_OFF` is the clock pulse after a shutdown has already set the latch.
- `ST_DRIVE` means the phase output is on.
- `ST_ENDED` means the latch is set.

Transitions:
- BLANK→DRIVE when blanking ends and the duty has not been reached.
- BLANK→ENDED when blanking ends and the duty has already been reached, or a shutdown is present at that edge.
- BLANK→BLANK_OFF on shutdown during blanking.
- BLANK_OFF→ENDED when blanking ends.
- DRIVE→ENDED on duty match or shutdown.
- Any state→BLANK on a period restart, which is the counter wrap or a sync pulse.

Top module: `pushpull_pwm`

## Requirements
- R1: While reset is high both drives are low. The first period after reset is a drive A period, and its first cycle carries the period strobe.
- R2: With no sync pulse, `period_stb` is high for exactly one cycle in every PERIOD cycles, and that cycle is position 0 of the period.
- R3: Both drives are low during the first B cycles of every period, where B = max(`dead_in`, 1). Position 0 is always blanked.
- R4: Let D be the captured duty. The drive of the active phase is high exactly at positions p with B <= p < min(D, PERIOD). A duty of 0 gives no pulse.
- R5: Periods alternate between drive A and drive B, and the two drives are never high in the same cycle.
- R6: Once the active drive has gone low after blanking, it stays low until the next period strobe, whatever the duty input does meanwhile.
- R7: In any cycle where `shutdown_in` is high, both drives are low in that same cycle. This holds during blanking as well as while driving. The current period then delivers no further pulse after the shutdown is released, and the following period is unaffected.
- R8: A cycle with `sync_in` high is the last cycle of the current period. The next cycle is position 0 of a new period, with the strobe raised and the phase toggled.
- R9: D is the value of `duty_in` in the last blanking cycle (position B-1). Changes to `duty_in` after blanking have no effect in that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| duty_in | input | CNT_W | Duty demand: ramp count at which the pulse ends |
| dead_in | input | CNT_W | Blanking length in cycles (minimum 1 applied) |
| sync_in | input | 1 | Restart the period after this cycle |
| shutdown_in | input | 1 | Immediate drive cut-off; sets the pulse latch |
| drive_a | output | 1 | Drive for phase A, high means on |
| drive_b | output | 1 | Drive for phase B, high means on |
| period_stb | output | 1 | High in the first cycle of each period |

## Verification
The checker assumes that every input is synchronous to `clk` and free of unknowns. It also assumes that a sync pulse is a plain level sampled at the edge, with no minimum spacing, so its period bound only requires a strobe within every PERIOD cycles. The bench changes inputs only at the falling edge and samples one time unit later, so the design sees them as clean synchronous levels. The bench holds `dead_in` below PERIOD so that each period contains a non-blanked region. Duty, shutdown and sync are placed at chosen period positions, including blanking cycles, the last blanking cycle and the final cycle of a period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    // Pulse latch states
    typedef enum logic [1:0] {
        ST_BLANK     = 2'd0,
        ST_BLANK_OFF = 2'd1,
        ST_DRIVE     = 2'd2,
        ST_ENDED     = 2'd3
    } latch_state_e;

    // Output steering phase
    typedef enum logic {
        PH_A = 1'b0,
        PH_B = 1'b1
    } phase_e;

endpackage

// File: rtl/pwm_ramp.sv
module pwm_ramp #(
    parameter int PERIOD = 64,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_in,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W:0]   cnt_inc,
    output logic             restart,
    output logic             first
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    assign cnt     = cnt_q;
    assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign restart = (cnt_q == LAST) || sync_in;
    assign first   = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/pwm_latch_fsm.sv
module pwm_latch_fsm
    import pwm_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [CNT_W:0]   cnt_inc,
    input  logic [CNT_W-1:0] duty_in,
    input  logic [CNT_W-1:0] dead_in,
    input  logic             shutdown_in,
    output logic             drive_on,
    output logic             blanking
);
    latch_state_e     state_q, state_n;
    logic [CNT_W-1:0] duty_q, duty_n;
    logic [CNT_W:0]   dead_ext, duty_live_ext, duty_held_ext;
    logic             blank_done;

    assign dead_ext      = {1'b0, dead_in};
    assign duty_live_ext = {1'b0, duty_in};
    assign duty_held_ext = {1'b0, duty_q};
    assign blank_done    = (cnt_inc >= dead_ext);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BLANK;
            duty_q  <= '0;
        end else begin
            state_q <= state_n;
            duty_q  <= duty_n;
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        duty_n  = duty_q;
        if ((state_q == ST_BLANK) || (state_q == ST_BLANK_OFF)) begin
            duty_n = duty_in;
        end
        if (restart) begin
            state_n = ST_BLANK;
        end else begin
            unique case (state_q)
                ST_BLANK: begin
                    if (blank_done) begin
                        if (!shutdown_in && (cnt_inc < duty_live_ext)) begin
                            state_n = ST_DRIVE;
                        end else begin
                            state_n = ST_ENDED;
                        end
                    end else if (shutdown_in) begin
                        state_n = ST_BLANK_OFF;
                    end
                end
                ST_BLANK_OFF: begin
                    if (blank_done) begin
                        state_n = ST_ENDED;
                    end
                end
                ST_DRIVE: begin
                    if (shutdown_in || (cnt_inc >= duty_held_ext)) begin
                        state_n = ST_ENDED;
                    end
                end
                ST_ENDED: begin
                    state_n = ST_ENDED;
                end
                default: begin
                    state_n = ST_BLANK;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        drive_on = (state_q == ST_DRIVE);
        blanking = (state_q == ST_BLANK) || (state_q == ST_BLANK_OFF);
    end

endmodule

// File: rtl/pwm_steer.sv
module pwm_steer
    import pwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic drive_on,
    input  logic shutdown_in,
    output logic drive_a,
    output logic drive_b
);
    phase_e phase_q;
    logic   gate;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_A;
        end else if (restart) begin
            phase_q <= (phase_q == PH_A) ? PH_B : PH_A;
        end
    end

    // Low unless the phase is selected, the latch is clear and no shutdown is present
    always_comb begin
        gate    = drive_on && !shutdown_in;
        drive_a = gate && (phase_q == PH_A);
        drive_b = gate && (phase_q == PH_B);
    end

endmodule

// File: rtl/pushpull_pwm.sv
module pushpull_pwm #(
    parameter int PERIOD = 64,
    localparam int CNT_W = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] duty_in,
    input  logic [CNT_W-1:0] dead_in,
    input  logic             sync_in,
    input  logic             shutdown_in,
    output logic             drive_a,
    output logic             drive_b,
    output logic             period_stb
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_inc;
    logic             restart;
    logic             first;
    logic             drive_on;
    logic             blanking;

    pwm_ramp #(
        .PERIOD (PERIOD),
        .CNT_W  (CNT_W)
    ) u_ramp (
        .clk     (clk),
        .rst     (rst),
        .sync_in (sync_in),
        .cnt     (cnt),
        .cnt_inc (cnt_inc),
        .restart (restart),
        .first   (first)
    );

    pwm_latch_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .restart     (restart),
        .cnt_inc     (cnt_inc),
        .duty_in     (duty_in),
        .dead_in     (dead_in),
        .shutdown_in (shutdown_in),
        .drive_on    (drive_on),
        .blanking    (blanking)
    );

    pwm_steer u_steer (
        .clk         (clk),
        .rst         (rst),
        .restart     (restart),
        .drive_on    (drive_on),
        .shutdown_in (shutdown_in),
        .drive_a     (drive_a),
        .drive_b     (drive_b)
    );

    // Position 0 of a period is always a blanking cycle
    assign period_stb = first && blanking;

endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
    parameter int PERIOD = 64
) (
    input logic clk,
    input logic rst,
    input logic sync_in,
    input logic shutdown_in,
    input logic drive_a,
    input logic drive_b,
    input logic period_stb
);
    localparam int GAP_W = $clog2(PERIOD) + 2;

    logic [GAP_W-1:0] since_stb;
    logic             was_hi;
    logic             ended_seen;
    logic             any_hi;
    logic             fell_now;

    assign any_hi   = drive_a || drive_b;
    assign fell_now = was_hi && !any_hi && !period_stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_stb  <= '0;
            was_hi     <= 1'b0;
            ended_seen <= 1'b0;
        end else begin
            since_stb  <= period_stb ? GAP_W'(1) : since_stb + GAP_W'(1);
            was_hi     <= any_hi;
            ended_seen <= period_stb ? 1'b0 : (ended_seen || fell_now);
        end
    end

    p_strobe_gap_r2: assert property (@(posedge clk) disable iff (rst)
        since_stb <= GAP_W'(PERIOD));

    p_strobe_blank_r3: assert property (@(posedge clk) disable iff (rst)
        period_stb |-> (!drive_a && !drive_b));

    p_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        !(drive_a && drive_b));

    p_no_repulse_r6: assert property (@(posedge clk) disable iff (rst)
        (ended_seen && !period_stb) |-> !any_hi);

    p_shutdown_off_r7: assert property (@(posedge clk) disable iff (rst)
        shutdown_in |-> (!drive_a && !drive_b));

    p_sync_restart_r8: assert property (@(posedge clk) disable iff (rst)
        sync_in |=> period_stb);

endmodule

bind pushpull_pwm pwm_checker #(
    .PERIOD (PERIOD)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sync_in     (sync_in),
    .shutdown_in (shutdown_in),
    .drive_a     (drive_a),
    .drive_b     (drive_b),
    .period_stb  (period_stb)
);

// File: tb/pushpull_pwm_test.sv
module pushpull_pwm_test;
    localparam int P = 16;
    localparam int W = $clog2(P);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] duty = '0;
    logic [W-1:0] dead = '0;
    logic         sync = 1'b0;
    logic         sd = 1'b0;
    logic         a, b, stb;

    int checks = 0;
    int errors = 0;
    int phase  = 0;

    always #5 clk = ~clk;

    pushpull_pwm #(.PERIOD(P)) uut (
        .clk         (clk),
        .rst         (rst),
        .duty_in     (duty),
        .dead_in     (dead),
        .sync_in     (sync),
        .shutdown_in (sd),
        .drive_a     (a),
        .drive_b     (b),
        .period_stb  (stb)
    );

    task automatic check(input string tag, input int pos, input logic [2:0] got, input logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s pos=%0d: a/b/stb=%b expected %b", tag, pos, got, exp);
        end
    endtask

    // One period: duty dd until chg_pos then chg_val; shutdown from sd_pos for sd_len cycles;
    // sync high at sync_pos (period ends there). Unused events use -1 / P.
    task automatic run_period(input string tag, input int dd, input int dl, input int chg_pos,
                              input int chg_val, input int sd_pos, input int sd_len, input int sync_pos);
        int bl;
        int cap;
        int top;
        int off_from;
        logic hi;
        logic [2:0] exp;
        bl       = (dl < 1) ? 1 : dl;
        cap      = ((bl - 1) >= chg_pos) ? chg_val : dd;
        top      = (cap < P) ? cap : P;
        off_from = (sd_pos < 0) ? P : sd_pos;
        for (int pos = 0; pos < P; pos++) begin
            @(negedge clk);
            duty = (pos >= chg_pos) ? chg_val[W-1:0] : dd[W-1:0];
            dead = dl[W-1:0];
            sd   = (sd_pos >= 0) && (pos >= sd_pos) && (pos < sd_pos + sd_len);
            sync = (pos == sync_pos);
            #1;
            hi  = (pos >= bl) && (pos < top) && (pos < off_from);
            exp = {(phase == 0) && hi, (phase == 1) && hi, pos == 0};
            check(tag, pos, {a, b, stb}, exp);
            if (pos == sync_pos) break;
        end
        phase ^= 1;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: run did not complete, got hang expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: drives low while in reset
        repeat (3) begin
            @(negedge clk);
            duty = W'(10);
            #1;
            checks++;
            if ({a, b} !== 2'b00) begin
                errors++;
                $display("FAIL R1 reset: a/b=%b expected 00", {a, b});
            end
        end
        @(posedge clk);
        #1 rst = 1'b0;

        // R1: first period is phase A with strobe at position 0
        run_period("R1", 10, 2, P, 0, -1, 0, -1);
        run_period("R5", 10, 2, P, 0, -1, 0, -1);

        // R2/R3/R4/R5: sweep dead time and duty
        for (int dl = 0; dl < 6; dl++) begin
            for (int dd = 0; dd < P; dd++) begin
                run_period("R2/R3/R4/R5", dd, dl, P, 0, -1, 0, -1);
            end
        end

        // R9: duty raised after blanking has no effect; R6: no second pulse
        run_period("R6/R9", 5, 2, 7, 15, -1, 0, -1);
        run_period("R6/R9", 5, 2, 7, 15, -1, 0, -1);
        // R9: duty lowered after blanking has no effect
        run_period("R9", 12, 3, 5, 1, -1, 0, -1);
        // R9: value at last blanking cycle is the one captured
        run_period("R9", 2, 4, 3, 11, -1, 0, -1);

        // R7: single-cycle shutdown mid-pulse, then a clean period
        run_period("R7", 12, 2, P, 0, 5, 1, -1);
        run_period("R7", 12, 2, P, 0, -1, 0, -1);
        // R7: shutdown during blanking only
        run_period("R7", 12, 4, P, 0, 1, 1, -1);
        run_period("R7", 12, 4, P, 0, 1, 1, -1);
        // R7: shutdown in last blanking cycle, and multi-cycle shutdown
        run_period("R7", 12, 3, P, 0, 2, 1, -1);
        run_period("R7", 15, 1, P, 0, 6, 4, -1);
        run_period("R7", 15, 1, P, 0, 14, 2, -1);
        run_period("R7", 15, 1, P, 0, -1, 0, -1);

        // R8: sync mid-pulse, in blanking, and at the last cycle
        run_period("R8", 12, 2, P, 0, -1, 0, 9);
        run_period("R8", 12, 2, P, 0, -1, 0, 1);
        run_period("R8", 12, 2, P, 0, -1, 0, 0);
        run_period("R8", 12, 2, P, 0, -1, 0, 15);
        run_period("R8", 12, 2, P, 0, -1, 0, -1);
        run_period("R8", 12, 2, P, 0, -1, 0, -1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule